// File: doc/BRIEF.md
# Configuration Access PIO Engine

This block lets software issue one PCIe configuration read or write at a time through a small set of word-indexed registers. Software chooses a 4-bit transaction kind, loads a 64-bit target address as two 32-bit halves, loads write data and a 4-bit byte-enable mask, and then writes the launch register. The engine presents one request on a simple valid/ready request port, waits for the matching completion on the completion port, and records the outcome.

When the completion arrives, the engine stores its 3-bit status code and, for read kinds, the full 32-bit completion word. Software picks out the bytes it needs from that word. It also sets a done flag in a write-1-to-clear interrupt register. If no completion arrives within a programmable number of cycles, the engine gives up, raises a separate timeout flag and returns to idle. While a request is outstanding, the launch register reads back as busy and the request-shaping registers are frozen.

Software forms the configuration address itself. The bus number goes in bits [27:20], the device in [19:15], the function in [14:12] and the dword-aligned register offset (mask 0xFFC) in the low bits. For a partial write, the byte-enable mask is a run of ones as long as the access size, shifted left by the low two offset bits. The data is shifted left by eight times that offset. Full-word reads use mask 0xF.

Top module: `cfg_pio_engine`

## Requirements
- R1: Launching drives `req_valid` high with `req_type`, `req_addr` = {ADDR_HI, ADDR_LO}, `req_wdata` and `req_strb` taken from the registers. `req_valid` stays high until a cycle with `req_ready` high, unless the timeout ends the request first.
- R2: A write with bit 0 set to the START register (index 7) while idle launches a request. The design raises `req_valid` in the cycle after the write. START bit 0 reads 1 while a request is outstanding and 0 otherwise. Writing 0 to START launches nothing.
- R3: A completion accepted while the request is waiting ends the request at that clock edge. The same edge sets ISR (index 8) bit 0 and copies `cpl_status` into STAT (index 1) bits [9:7]. STAT keeps the raw code: 0 ok, 1 unsupported, 2 retry, 4 abort, and any other value is kept as received.
- R4: STAT bit 0 is 1 for non-posted kinds (kind bit 3 set, i.e. 0x8 read type 0, 0x9 read type 1, 0xA write type 0, 0xB write type 1) and 0 for any other kind. A posted kind finishes when the request is accepted, sets ISR bit 0 and records status 0 without waiting for a completion.
- R5: For read kinds 0x8 and 0x9, the completion word is stored in RDATA (index 6). Completions for write kinds leave RDATA unchanged.
- R6: Writing 1 to an ISR bit clears it. `irq` is the OR of ISR bits 0 and 1. If a flag sets and is cleared in the same cycle, the set wins.
- R7: If a request is still outstanding after TMO (index 9) cycles counted from the launch edge, it ends, ISR bit 1 sets and ISR bit 0 does not. A TMO of 0 disables the limit.
- R8: While a request is outstanding, writes to CTRL, ADDR_LO (index 2), ADDR_HI (index 3), WDATA (index 4), STRB (index 5), TMO and START are ignored.
- R9: CTRL (index 0) bits [3:0] set the kind. CTRL bit 24 is sent as `req_win_bypass`, which asks for the outbound address-window translation to be skipped.
- R10: A completion that arrives while no request is waiting for one changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted |
| req_type | output | 4 | Transaction kind |
| req_addr | output | 64 | Target address |
| req_wdata | output | 32 | Write data |
| req_strb | output | 4 | Byte enables |
| req_win_bypass | output | 1 | Skip outbound window translation |
| cpl_valid | input | 1 | Completion valid |
| cpl_status | input | 3 | Completion status code |
| cpl_data | input | 32 | Completion data word |
| irq | output | 1 | Interrupt, OR of pending flags |

## Verification
The bench builds the engine with an 8-bit timeout counter and a reset limit of 20 cycles. With those values, timeouts in both the issue phase and the wait phase occur within a few cycles. A run with the limit set to 0 can be held for 300 cycles, which takes the 8-bit counter past its wrap point and shows that no timeout fires. The bench sweeps every legal pairing of access size (1, 2 or 4 bytes) and byte offset for configuration writes, and it computes the expected address packing, byte-enable mask and shifted data arithmetically. Reads sweep all eight completion status codes.

// File: rtl/cfg_pio_pkg.sv
`timescale 1ns/1ps
package cfg_pio_pkg;

    localparam int IDX_W = 4;

    localparam logic [IDX_W-1:0] RI_CTRL    = 4'd0;
    localparam logic [IDX_W-1:0] RI_STAT    = 4'd1;
    localparam logic [IDX_W-1:0] RI_ADDR_LO = 4'd2;
    localparam logic [IDX_W-1:0] RI_ADDR_HI = 4'd3;
    localparam logic [IDX_W-1:0] RI_WDATA   = 4'd4;
    localparam logic [IDX_W-1:0] RI_STRB    = 4'd5;
    localparam logic [IDX_W-1:0] RI_RDATA   = 4'd6;
    localparam logic [IDX_W-1:0] RI_START   = 4'd7;
    localparam logic [IDX_W-1:0] RI_ISR     = 4'd8;
    localparam logic [IDX_W-1:0] RI_TMO     = 4'd9;

    localparam int BYPASS_BIT = 24;
    localparam int CODE_LSB   = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [3:0]  kind;
        logic        bypass;
        logic [63:0] addr;
        logic [31:0] wdata;
        logic [3:0]  strb;
    } pio_req_t;

    function automatic logic is_nonposted(input logic [3:0] k);
        return k[3];
    endfunction

    function automatic logic is_read(input logic [3:0] k);
        return k[3] & ~k[1];
    endfunction

endpackage

// File: rtl/cfg_pio_seq.sv
`timescale 1ns/1ps
module cfg_pio_seq
    import cfg_pio_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             posted,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             req_ready,
    input  logic             cpl_valid,
    output logic             busy,
    output logic             req_valid,
    output logic             done,
    output logic             done_cpl,
    output logic             abort
);

    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    seq_state_e       st;
    logic [TMO_W-1:0] cnt;
    logic             tmo_en;
    logic             tmo_hit;

    assign tmo_en    = |tmo_limit;
    assign tmo_hit   = tmo_en && (cnt == tmo_limit - ONE);
    assign busy      = (st != ST_IDLE);
    assign req_valid = (st == ST_ISSUE);
    assign done_cpl  = (st == ST_WAIT) && cpl_valid;
    assign done      = done_cpl || (req_valid && req_ready && posted);
    assign abort     = busy && !done && tmo_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (st == ST_IDLE) begin
            if (launch) begin
                st  <= ST_ISSUE;
                cnt <= '0;
            end
        end else if (done || abort) begin
            st <= ST_IDLE;
        end else begin
            if (st == ST_ISSUE && req_ready) st <= ST_WAIT;
            cnt <= cnt + ONE;
        end
    end

    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
        (busy && tmo_en) |-> (cnt < tmo_limit)); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !abort) |=> req_valid); // R1
    AST_CPL_ENDS: assert property (@(posedge clk) disable iff (rst)
        done_cpl |=> !busy); // R3
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !launch) |=> !busy); // R10

endmodule

// File: rtl/cfg_pio_regfile.sv
`timescale 1ns/1ps
module cfg_pio_regfile
    import cfg_pio_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int TMO_DEFAULT = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [31:0]      rdata,
    input  logic             busy,
    input  logic             done,
    input  logic             done_cpl,
    input  logic             abort,
    input  logic [2:0]       cpl_status,
    input  logic [31:0]      cpl_data,
    output logic             launch,
    output pio_req_t         req,
    output logic [TMO_W-1:0] tmo_limit,
    output logic             irq
);

    logic        np_q;
    logic [2:0]  code_q;
    logic [31:0] rdata_q;
    logic [1:0]  isr_q;
    logic        cfg_we;

    assign cfg_we = we && !busy;
    assign launch = cfg_we && (waddr == RI_START) && wdata[0];
    assign irq    = |isr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req       <= '0;
            np_q      <= 1'b0;
            code_q    <= '0;
            rdata_q   <= '0;
            isr_q     <= '0;
            tmo_limit <= TMO_W'(TMO_DEFAULT);
        end else begin
            if (cfg_we) begin
                case (waddr)
                    RI_CTRL: begin
                        req.kind   <= wdata[3:0];
                        req.bypass <= wdata[BYPASS_BIT];
                    end
                    RI_ADDR_LO: req.addr[31:0]  <= wdata;
                    RI_ADDR_HI: req.addr[63:32] <= wdata;
                    RI_WDATA:   req.wdata       <= wdata;
                    RI_STRB:    req.strb        <= wdata[3:0];
                    RI_TMO:     tmo_limit       <= wdata[TMO_W-1:0];
                    default: ;
                endcase
            end
            if (launch) np_q <= is_nonposted(req.kind);
            if (done) code_q <= done_cpl ? cpl_status : 3'd0;
            if (done_cpl && is_read(req.kind)) rdata_q <= cpl_data;
            if (we && waddr == RI_ISR) isr_q <= isr_q & ~wdata[1:0];
            if (done)  isr_q[0] <= 1'b1;
            if (abort) isr_q[1] <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        case (raddr)
            RI_CTRL: begin
                rdata[3:0]        = req.kind;
                rdata[BYPASS_BIT] = req.bypass;
            end
            RI_STAT: begin
                rdata[0]                   = np_q;
                rdata[CODE_LSB+2:CODE_LSB] = code_q;
            end
            RI_ADDR_LO: rdata = req.addr[31:0];
            RI_ADDR_HI: rdata = req.addr[63:32];
            RI_WDATA:   rdata = req.wdata;
            RI_STRB:    rdata[3:0] = req.strb;
            RI_RDATA:   rdata = rdata_q;
            RI_START:   rdata[0] = busy;
            RI_ISR:     rdata[1:0] = isr_q;
            RI_TMO:     rdata[TMO_W-1:0] = tmo_limit;
            default: ;
        endcase
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(req) && $stable(tmo_limit))); // R8
    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (rst)
        done |=> (irq && isr_q[0])); // R3
    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (rst)
        abort |=> isr_q[1]); // R7
    AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(done_cpl && is_read(req.kind)) |=> $stable(rdata_q)); // R5

endmodule

// File: rtl/cfg_pio_engine.sv
`timescale 1ns/1ps
module cfg_pio_engine
    import cfg_pio_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int TMO_DEFAULT = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [3:0]  req_type,
    output logic [63:0] req_addr,
    output logic [31:0] req_wdata,
    output logic [3:0]  req_strb,
    output logic        req_win_bypass,
    input  logic        cpl_valid,
    input  logic [2:0]  cpl_status,
    input  logic [31:0] cpl_data,
    output logic        irq
);

    pio_req_t         req;
    logic [TMO_W-1:0] tmo_limit;
    logic             launch;
    logic             busy;
    logic             done;
    logic             done_cpl;
    logic             abort;

    cfg_pio_regfile #(
        .TMO_W       (TMO_W),
        .TMO_DEFAULT (TMO_DEFAULT)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .waddr      (reg_waddr),
        .wdata      (reg_wdata),
        .raddr      (reg_raddr),
        .rdata      (reg_rdata),
        .busy       (busy),
        .done       (done),
        .done_cpl   (done_cpl),
        .abort      (abort),
        .cpl_status (cpl_status),
        .cpl_data   (cpl_data),
        .launch     (launch),
        .req        (req),
        .tmo_limit  (tmo_limit),
        .irq        (irq)
    );

    cfg_pio_seq #(
        .TMO_W (TMO_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .posted    (!is_nonposted(req.kind)),
        .tmo_limit (tmo_limit),
        .req_ready (req_ready),
        .cpl_valid (cpl_valid),
        .busy      (busy),
        .req_valid (req_valid),
        .done      (done),
        .done_cpl  (done_cpl),
        .abort     (abort)
    );

    assign req_type       = req.kind;
    assign req_addr       = req.addr;
    assign req_wdata      = req.wdata;
    assign req_strb       = req.strb;
    assign req_win_bypass = req.bypass;

endmodule

// File: tb/test_cfg_pio_engine.sv
`timescale 1ns/1ps
module test_cfg_pio_engine;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [3:0]  reg_waddr;
    logic [31:0] reg_wdata;
    logic [3:0]  reg_raddr;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready;
    logic [3:0]  req_type;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        req_win_bypass;
    logic        cpl_valid;
    logic [2:0]  cpl_status;
    logic [31:0] cpl_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cfg_pio_engine #(.TMO_W(8), .TMO_DEFAULT(20)) i_cfg_pio_engine (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .req_win_bypass(req_win_bypass),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status), .cpl_data(cpl_data),
        .irq(irq)
    );

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic handshake();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
    endtask

    task automatic complete(input logic [2:0] code, input logic [31:0] data);
        handshake();
        cpl_valid = 1'b1; cpl_status = code; cpl_data = data;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] last_rd;
        rst = 1'b1; reg_we = 0; reg_waddr = 0; reg_wdata = 0; reg_raddr = 0;
        req_ready = 0; cpl_valid = 0; cpl_status = 0; cpl_data = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        rd(4'd7, v); chk("R2 reset start", v, 0);
        rd(4'd8, v); chk("R6 reset isr", v, 0);
        chk("R6 reset irq", irq, 0);
        chk("R1 reset req_valid", req_valid, 0);
        rd(4'd9, v); chk("R7 reset tmo", v, 20);

        // R1/R4/R8/R9: config write sweep over size and offset
        for (int sz = 1; sz <= 4; sz = sz * 2) begin
            for (int off = 0; off < 4; off++) begin
                if (off + sz <= 4) begin
                    logic [31:0] mask, wd, addr, ctrl;
                    logic [3:0]  strb, kind;
                    int bus, dev, fn, where;
                    bus = 16 + off * 3 + sz; dev = sz * 5 + off; fn = off + sz;
                    where = 64 * sz + 4 * off + off;
                    addr = ((bus & 255) << 20) | ((dev & 31) << 15) | ((fn & 7) << 12) | (where & 'hFFC);
                    mask = (sz == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * sz)) - 1);
                    wd   = (32'hDEAD_BEEF & mask) << (8 * off);
                    strb = 4'(((1 << sz) - 1) << off);
                    kind = (off % 2 == 1) ? 4'hB : 4'hA;
                    ctrl = {28'd0, kind} | ((sz == 2) ? 32'h0100_0000 : 32'd0);
                    wr(4'd7, 0); wr(4'd8, 3);
                    wr(4'd0, ctrl); wr(4'd2, addr); wr(4'd3, 32'(sz * 256 + off));
                    wr(4'd4, wd); wr(4'd5, {28'd0, strb});
                    wr(4'd7, 1);
                    chk("R1 req_valid", req_valid, 1);
                    chk("R1 req_type", req_type, kind);
                    chk("R1 req_addr", req_addr, {32'(sz * 256 + off), addr});
                    chk("R1 req_wdata", req_wdata, wd);
                    chk("R1 req_strb", req_strb, strb);
                    chk("R9 bypass", req_win_bypass, (sz == 2) ? 1 : 0);
                    rd(4'd7, v); chk("R2 start busy", v, 1);
                    wr(4'd2, ~addr);
                    chk("R8 addr frozen", req_addr, {32'(sz * 256 + off), addr});
                    complete(3'd0, 32'h0);
                    rd(4'd1, v); chk("R4 stat nonposted", v, 1);
                    rd(4'd7, v); chk("R3 start idle", v, 0);
                    rd(4'd8, v); chk("R3 isr done", v, 1);
                    chk("R6 irq", irq, 1);
                end
            end
        end

        // R3/R5/R6: read with every status code
        for (int code = 0; code < 8; code++) begin
            logic [31:0] d;
            d = (32'h1111_1111 * code) ^ 32'hC0FF_EE00;
            wr(4'd8, 3);
            wr(4'd0, (code % 2 == 1) ? 32'h9 : 32'h8);
            wr(4'd2, 32'(256 + code * 4));
            wr(4'd7, 1);
            complete(3'(code), d);
            rd(4'd1, v); chk("R3 status code", v, 32'((code << 7) | 1));
            rd(4'd6, v); chk("R5 read data", v, d);
            last_rd = d;
            rd(4'd8, v); chk("R3 isr done", v, 1);
            wr(4'd8, 1);
            rd(4'd8, v); chk("R6 isr cleared", v, 0);
            chk("R6 irq low", irq, 0);
        end

        // R4: posted kind completes on acceptance
        wr(4'd0, 32'h2); wr(4'd7, 1);
        chk("R4 posted req_valid", req_valid, 1);
        handshake();
        rd(4'd7, v); chk("R4 posted idle", v, 0);
        rd(4'd1, v); chk("R4 posted stat", v, 0);
        rd(4'd8, v); chk("R4 posted isr", v, 1);
        wr(4'd8, 1);

        // R5: write completion leaves read data
        wr(4'd0, 32'hA); wr(4'd7, 1);
        complete(3'd0, 32'h1234_5678);
        rd(4'd6, v); chk("R5 write keeps rdata", v, last_rd);
        rd(4'd1, v); chk("R3 write stat", v, 1);
        wr(4'd8, 1);

        // R10: stray completion while idle
        @(negedge clk); cpl_valid = 1; cpl_status = 3'd4; cpl_data = 32'hFFFF_FFFF;
        @(negedge clk); cpl_valid = 0;
        rd(4'd8, v); chk("R10 isr untouched", v, 0);
        rd(4'd1, v); chk("R10 stat untouched", v, 1);
        rd(4'd6, v); chk("R10 rdata untouched", v, last_rd);
        chk("R10 irq low", irq, 0);

        // R2: writing 0 to START launches nothing
        wr(4'd7, 0);
        chk("R2 no launch", req_valid, 0);
        rd(4'd7, v); chk("R2 start idle", v, 0);

        // R7: timeout while issuing
        wr(4'd9, 5); rd(4'd9, v); chk("R7 tmo reg", v, 5);
        wr(4'd0, 32'h8); wr(4'd7, 1);
        repeat (4) @(negedge clk);
        rd(4'd7, v); chk("R7 busy before limit", v, 1);
        @(negedge clk);
        rd(4'd7, v); chk("R7 idle at limit", v, 0);
        rd(4'd8, v); chk("R7 isr timeout", v, 2);
        chk("R7 irq", irq, 1);
        wr(4'd8, 3);

        // R7: timeout while waiting for completion
        wr(4'd7, 1);
        handshake();
        repeat (3) @(negedge clk);
        rd(4'd8, v); chk("R7 wait timeout", v, 2);
        chk("R7 req_valid low", req_valid, 0);
        wr(4'd8, 3);

        // R7: limit 0 disables timeout
        wr(4'd9, 0); wr(4'd7, 1);
        repeat (300) @(negedge clk);
        rd(4'd7, v); chk("R7 no timeout", v, 1);
        wr(4'd9, 7);
        rd(4'd9, v); chk("R8 tmo frozen", v, 0);
        complete(3'd2, 32'h0);
        rd(4'd1, v); chk("R3 retry code", v, 32'((2 << 7) | 1));
        rd(4'd8, v); chk("R7 no timeout flag", v, 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule